// File: doc/BRIEF.md
# Readback Bus Register with Polarity

This block is a byte-wide edge-triggered storage register that sits on a shared data bus. While its active-low enable is asserted, it takes the bus value on each rising clock edge. With the same enable asserted and an active-low read request also asserted, it drives the stored byte back onto that bus so other agents can read it. The bidirectional bus is split into an input, an output and an output-enable, so the block can be synthesised.

A separate output port presents the stored byte. A polarity input selects whether this port shows the byte as stored or its bitwise complement. The port has its own active-low output enable, and when that enable is off the port is modelled as high impedance. A synchronous active-low reset clears the stored byte to zero. A simulation check flags any change of the enable while the clock is low, because such a change could cause a false capture.

Top module: `readback_bus_reg`

## Requirements
- R1: A rising clock edge with rst_n low clears the stored byte to 0x00, whatever the values of en_n and bus_in.
- R2: A rising clock edge with rst_n high, en_n low and rd_n high stores bus_in.
- R3: A rising clock edge with en_n high leaves the stored byte unchanged, whatever bus_in and rd_n are.
- R4: bus_oe is 1 exactly when en_n and rd_n are both 0, and while bus_oe is 1, bus_out equals the stored byte.
- R5: bus_out is 0x00 whenever bus_oe is 0.
- R6: A rising clock edge with en_n and rd_n both 0 reloads the value already held, so the stored byte stays the same whatever bus_in is.
- R7: While q_oe is 1 and pol_true is 1, q_out equals the stored byte.
- R8: While q_oe is 1 and pol_true is 0, q_out equals the bitwise complement of the stored byte.
- R9: q_oe equals the inverse of qoe_n. While q_oe is 0, q_out is 0x00 (high impedance), and storing still works.
- R10: en_n may change only while clk is high. A change while clk is low is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low enable for storing and readback |
| rd_n | input | 1 | Active-low readback request |
| pol_true | input | 1 | 1: q_out shows the stored byte; 0: q_out shows its complement |
| qoe_n | input | 1 | Active-low enable of the q_out port |
| bus_in | input | WIDTH | Data arriving from the shared bus |
| bus_out | output | WIDTH | Stored byte driven toward the bus during readback |
| bus_oe | output | 1 | Bus driver enable |
| q_out | output | WIDTH | Stored byte, true or inverted |
| q_oe | output | 1 | 1 when q_out is driven; 0 means high impedance |

## Verification
The vector walk alternates between stores, holds with en_n high, and readbacks. Each store puts in a new byte (0xA5, 0x3C, 0x81, 0xFF), so a missed capture and a capture during a hold give different values on q_out. Readback cycles put a bus_in value on the bus that differs from the stored byte. A design that takes bus_in during readback therefore changes q_out one cycle later, where a correct design does not. The polarity input is switched while the same byte is held, which separates true and inverted output. Directed tests check that reset wins over a pending store, and that a store still happens while q_out is disabled.

// File: rtl/rbr_pkg.sv
// Shared types for the readback bus register.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rbr_pkg;

    // Action the storage register takes on the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_CLEAR  = 2'd3
    } store_act_t;

endpackage

// File: rtl/rbr_ctrl.sv
// Decodes the control pins into a storage action and a bus-drive enable.
// Assumes: the enable is stable around the rising edge; reset has priority.
module rbr_ctrl
    import rbr_pkg::*;
(
    input  logic       rst_n,
    input  logic       en_n,
    input  logic       rd_n,
    output store_act_t act,
    output logic       drive_bus
);

    // Choose the storage action; reset wins, then enable, then read request.
    always_comb begin
        if (!rst_n)
            act = ACT_CLEAR;
        else if (en_n)
            act = ACT_HOLD;
        else if (!rd_n)
            act = ACT_RELOAD;
        else
            act = ACT_LOAD;
    end

    // The bus is driven only while both active-low controls are asserted.
    always_comb begin
        drive_bus = (~en_n) & (~rd_n);
    end

endmodule

// File: rtl/rbr_store.sv
// Edge-triggered storage register carrying out the decoded action.
// Assumes: act is settled before the rising edge of clk.
module rbr_store
    import rbr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  store_act_t       act,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] stored
);

    localparam logic [WIDTH-1:0] CLEAR_VAL = '0;

    logic [WIDTH-1:0] next_val;

    // Select the value the register takes on the coming edge.
    always_comb begin
        unique case (act)
            ACT_CLEAR:  next_val = CLEAR_VAL;
            ACT_LOAD:   next_val = din;
            ACT_RELOAD: next_val = stored;
            default:    next_val = stored;
        endcase
    end

    // Register the selected value on each rising edge.
    always_ff @(posedge clk) begin
        stored <= next_val;
    end

endmodule

// File: rtl/rbr_qpath.sv
// Polarity selection and three-state gating for the byte output port.
// Assumes: high impedance is shown as zero data with the enable flag low.
module rbr_qpath #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] stored,
    input  logic             pol_true,
    input  logic             oe_n,
    output logic [WIDTH-1:0] q,
    output logic             q_en
);

    logic invert;

    // Turn the polarity select into an inversion flag shared by all bits.
    always_comb begin
        invert = ~pol_true;
        q_en   = ~oe_n;
    end

    // One inverting, gated slice per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Apply the polarity, then the output gate.
        always_comb begin
            q[i] = (stored[i] ^ invert) & q_en;
        end
    end

endmodule

// File: rtl/readback_bus_reg.sv
// Top: byte register on a shared bus, with readback and a polarity output.
// Assumes: en_n changes only while clk is high; the bus is split into in/out/oe.
module readback_bus_reg
    import rbr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             rd_n,
    input  logic             pol_true,
    input  logic             qoe_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic [WIDTH-1:0] q_out,
    output logic             q_oe
);

    store_act_t       act;
    logic             drive_bus;
    logic [WIDTH-1:0] stored_q;

    rbr_ctrl u_ctrl (
        .rst_n     (rst_n),
        .en_n      (en_n),
        .rd_n      (rd_n),
        .act       (act),
        .drive_bus (drive_bus)
    );

    rbr_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .act    (act),
        .din    (bus_in),
        .stored (stored_q)
    );

    rbr_qpath #(.WIDTH(WIDTH)) u_qpath (
        .stored   (stored_q),
        .pol_true (pol_true),
        .oe_n     (qoe_n),
        .q        (q_out),
        .q_en     (q_oe)
    );

    // Drive the bus only during readback; otherwise leave it zero.
    always_comb begin
        bus_oe  = drive_bus;
        bus_out = drive_bus ? stored_q : '0;
    end

endmodule

// File: rtl/rbr_checker.sv
// Assertion checker for readback_bus_reg, attached with bind below.
// Assumes: stored is the top's internal register value.
module rbr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_n,
    input logic             rd_n,
    input logic             pol_true,
    input logic             qoe_n,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic [WIDTH-1:0] q_out,
    input logic             q_oe,
    input logic [WIDTH-1:0] stored
);

    logic en_at_fall;
    logic fall_seen = 1'b0;

    // Record the enable at each falling edge for the timing check.
    always_ff @(negedge clk) begin
        en_at_fall <= en_n;
        fall_seen  <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> stored == '0);

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && rd_n) |=> stored == $past(bus_in));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(stored));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !rd_n) |=> $stable(stored));

    // R4
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !rd_n) |-> (bus_oe && bus_out == stored));

    // R5
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_out == '0);

    // R7
    pol_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_oe && pol_true) |-> q_out == stored);

    // R8
    pol_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_oe && !pol_true) |-> q_out == ~stored);

    // R9
    q_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qoe_n |-> (!q_oe && q_out == '0));

    // R10
    en_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_seen |-> en_n == en_at_fall);

endmodule

bind readback_bus_reg rbr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_n     (en_n),
    .rd_n     (rd_n),
    .pol_true (pol_true),
    .qoe_n    (qoe_n),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .q_out    (q_out),
    .q_oe     (q_oe),
    .stored   (stored_q)
);

// File: tb/readback_bus_reg_test.sv
// Self-checking bench: vector walk, then directed reset and gating tests.
module readback_bus_reg_test;

    localparam int W = 8;
    localparam int NVEC = 11;

    // {en_n, rd_n, pol_true, qoe_n, bus_in, expected q_out, expected bus_out}
    // Expected values are sampled before the edge that consumes the vector.
    localparam logic [27:0] VEC [NVEC] = '{
        28'h6A50000, 28'hE3CA500, 28'h2FFA5A5, 28'h43C5A00,
        28'h800C300, 28'h7810000, 28'h0007E81, 28'hE558100,
        28'h6FF8100, 28'h01200FF, 28'hE00FF00
    };

    logic         clk = 1'b0;
    logic         rst_n, en_n, rd_n, pol_true, qoe_n;
    logic [W-1:0] bus_in, bus_out, q_out;
    logic         bus_oe, q_oe;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    readback_bus_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .rd_n(rd_n),
        .pol_true(pol_true), .qoe_n(qoe_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .q_out(q_out), .q_oe(q_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive after a rising edge, while clk is high (R10).
    task automatic drive(input logic r, input logic e, input logic d,
                         input logic p, input logic o, input logic [W-1:0] b);
        @(posedge clk);
        #1;
        rst_n = r; en_n = e; rd_n = d; pol_true = p; qoe_n = o; bus_in = b;
    endtask

    initial begin
        rst_n = 1'b0; en_n = 1'b1; rd_n = 1'b1; pol_true = 1'b1; qoe_n = 1'b0; bus_in = '0;
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check("R1 reset value", q_out, 8'h00);
        check("R5 idle bus", bus_out, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] v;
            v = VEC[i];
            drive(1'b1, v[27], v[26], v[25], v[24], v[23:16]);
            @(negedge clk);
            check(v[24] ? "R9 q off" : (v[25] ? "R7 true q / R2 R3 R6 history" : "R8 inverted q / R2 R3 R6 history"),
                  q_out, v[15:8]);
            check("R4 R5 bus_out", bus_out, v[7:0]);
            check("R4 bus_oe", {7'd0, bus_oe}, {7'd0, ~v[27] & ~v[26]});
            check("R9 q_oe", {7'd0, q_oe}, {7'd0, ~v[24]});
        end

        // Stored byte is 0xFF now; reset must win over a pending store (R1).
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h77);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check("R1 reset beats store", q_out, 8'h00);

        // Store while q port disabled, then enable it (R9, R2).
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h6D);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
        @(negedge clk);
        check("R9 disabled q zero", q_out, 8'h00);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        check("R9 R8 store while disabled", q_out, 8'h92);

        // Readback with a conflicting bus value; read back in the next cycle (R6, R4).
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        @(negedge clk);
        check("R6 R4 readback keeps byte", bus_out, 8'h6D);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule